// File: doc/BRIEF.md
# Split-Node Row-Layer Min-Sum Processor

This block performs one decoding iteration on a single row-layer of a spatially coupled LDPC code with a coupling width of one. The layer spans two sub-blocks of `NV` variable nodes each. The left half faces the previous layer and the right half faces the next layer. The layer has `NC` check nodes. Every variable node is split in two. Each half keeps its own partial a-posteriori (APP) value, and the halves of neighbouring layers are tied together through exchange messages. Channel information lives only inside the APP registers: a load puts the channel LLRs into the right half and zeros into the left half.

Each iteration call does four things in order. It first folds the incoming exchange messages into the local APP values. It then derives variable-to-check messages by taking off the stored check messages. Next it runs a normalized min-sum update with a factor of 0.75. Finally it rebuilds the APP values and emits new outgoing exchange messages. Control inputs mark the first and the last sub-block of a code block, so the neighbour that does not exist is replaced by a neutral or a termination value.

The parity-check wiring is computed from parameters. Each check node has `DCH` edges into each half.
- Left edge k of check m goes to variable node (m·DCH + k) mod NV.
- Right edge k of check m goes to variable node (m·DCH + k + RSH) mod NV.

Top module: `sc_row_proc`

## Requirements
- R1: After reset, every APP value, every stored check message and every outgoing exchange value is zero, and `valid_o` is low.
- R2: A load (`load_i` high) has priority over `valid_i`. After the load clock edge:
  - each right APP equals the matching channel LLR, clamped to [-31, 31];
  - each left APP is 0;
  - all stored check messages and outgoing exchange values are 0;
  - `valid_o` is low.
- R3: At the start of an iteration the effective left input is added to each left APP and the effective right input to each right APP. Each sum saturates to [-31, 31]. All APP and exchange values are 6-bit two's complement and never hold -32.
- R4: When `first_i` is high, the effective left input is 0 for every node, whatever `xin_left_i` carries.
- R5: When `last_i` is high, the effective right input is `TERM_LLR` (default 31) for every node, whatever `xin_right_i` carries.
- R6: For each edge, the variable-to-check message is sat6(APP after R3 − stored message). The new check message has these parts:
  - its sign is the XOR of the signs of the other edges of that check, where negative is set and zero counts as positive;
  - its magnitude is the scaled minimum of the other edges' magnitudes;
  - it is stored as a 4-bit two's complement value in [-7, 7].
- R7: Scaling maps a magnitude x to x − (x>>2), capped at 7. For example, 4→3, 8→6, 9→7 and 31→7.
- R8: The new APP of a node is the APP after R3 plus the sum, over that node's edges in the same half, of (new message − old message). It is saturated once to [-31, 31].
- R9: Each outgoing exchange value is sat6(new APP of that half − effective input of that half).
- R10: `valid_o` is high on exactly the cycle after an accepted iteration (`valid_i` high, `load_i` low) and low otherwise. All outputs are registered.
- R11: With neither `load_i` nor `valid_i` high, APP values, check messages and outgoing exchange values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load channel LLRs and clear state |
| chan_i | input | NV*6 | Channel LLRs, node j at bits [6j+5:6j] |
| valid_i | input | 1 | Run one iteration |
| first_i | input | 1 | First sub-block: left input neutral |
| last_i | input | 1 | Last sub-block: right input is termination value |
| xin_left_i | input | NV*6 | Exchange messages arriving at the left half |
| xin_right_i | input | NV*6 | Exchange messages arriving at the right half |
| valid_o | output | 1 | Iteration result valid |
| app_left_o | output | NV*6 | Left partial APP registers |
| app_right_o | output | NV*6 | Right partial APP registers |
| xout_left_o | output | NV*6 | Outgoing exchange messages of the left half |
| xout_right_o | output | NV*6 | Outgoing exchange messages of the right half |

## Verification
The range assertions assume that the internal saturation keeps -32 out of every register. That holds for any input, including -32 on the exchange or channel inputs, so the stimulus drives such values on purpose. The handshake assertions assume that `load_i` and `valid_i` are ordinary single-cycle controls. The bench drives them as pulses, sometimes both together, to exercise the load priority. Its first/last flags are drawn at random, so the neutral and termination substitutions occur in runs of iterations that also carry non-zero stored check messages.

// File: rtl/sc_row_pkg.sv
package sc_row_pkg;
  localparam int QAPP = 6;
  localparam int QEXT = 4;
  localparam int APP_LIM = 2 ** (QAPP - 1) - 1;
  localparam int EXT_LIM = 2 ** (QEXT - 1) - 1;

  typedef logic signed [QAPP-1:0] app_t;
  typedef logic signed [QEXT-1:0] ext_t;

  function automatic app_t sat_app(input int x);
    int y;
    y = (x > APP_LIM) ? APP_LIM : ((x < -APP_LIM) ? -APP_LIM : x);
    return y[QAPP-1:0];
  endfunction

  function automatic ext_t sat_ext(input int x);
    int y;
    y = (x > EXT_LIM) ? EXT_LIM : ((x < -EXT_LIM) ? -EXT_LIM : x);
    return y[QEXT-1:0];
  endfunction

  // normalized min-sum, factor 0.75, truncating
  function automatic int scale_mag(input int mag);
    int s;
    s = mag - (mag >> 2);
    return (s > EXT_LIM) ? EXT_LIM : s;
  endfunction

  function automatic int vn_idx(input int m, input int h, input int k,
                                input int nv, input int dch, input int rsh);
    return (m * dch + k + ((h != 0) ? rsh : 0)) % nv;
  endfunction
endpackage

// File: rtl/sc_row_xadd.sv
module sc_row_xadd
  import sc_row_pkg::*;
#(
  parameter int unsigned N   = 8,
  parameter bit          SUB = 1'b0
) (
  input  app_t a_i [N],
  input  app_t b_i [N],
  output app_t y_o [N]
);
  for (genvar j = 0; j < N; j++) begin : g_lane
    if (SUB) begin : g_sub
      assign y_o[j] = sat_app(int'(a_i[j]) - int'(b_i[j]));
    end else begin : g_add
      assign y_o[j] = sat_app(int'(a_i[j]) + int'(b_i[j]));
    end
  end
endmodule

// File: rtl/sc_row_cnu.sv
module sc_row_cnu
  import sc_row_pkg::*;
#(
  parameter int unsigned DEG = 8
) (
  input  app_t v2c_i [DEG],
  output ext_t c2v_o [DEG]
);
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;

  int            mag   [DEG];
  logic [DEG-1:0] neg;
  int            min0, min1;
  logic [IW-1:0] idx0;
  logic          par;

  always_comb begin
    min0 = APP_LIM;
    min1 = APP_LIM;
    idx0 = '0;
    par  = 1'b0;
    for (int k = 0; k < DEG; k++) begin
      neg[k] = v2c_i[k][QAPP-1];
      mag[k] = neg[k] ? -int'(v2c_i[k]) : int'(v2c_i[k]);
      par    = par ^ neg[k];
      if (mag[k] < min0) begin
        min1 = min0;
        min0 = mag[k];
        idx0 = IW'(k);
      end else if (mag[k] < min1) begin
        min1 = mag[k];
      end
    end
  end

  for (genvar k = 0; k < DEG; k++) begin : g_edge
    int m_sel, m_sc;
    always_comb begin
      m_sel = (idx0 == IW'(k)) ? min1 : min0;
      m_sc  = scale_mag(m_sel);
      c2v_o[k] = sat_ext((par ^ neg[k]) ? -m_sc : m_sc);
    end
  end
endmodule

// File: rtl/sc_row_proc.sv
module sc_row_proc
  import sc_row_pkg::*;
#(
  parameter int unsigned NV       = 8,
  parameter int unsigned NC       = 4,
  parameter int unsigned DCH      = 4,
  parameter int unsigned RSH      = 2,
  parameter int          TERM_LLR = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NV*QAPP-1:0] chan_i,
  input  logic               valid_i,
  input  logic               first_i,
  input  logic               last_i,
  input  logic [NV*QAPP-1:0] xin_left_i,
  input  logic [NV*QAPP-1:0] xin_right_i,
  output logic               valid_o,
  output logic [NV*QAPP-1:0] app_left_o,
  output logic [NV*QAPP-1:0] app_right_o,
  output logic [NV*QAPP-1:0] xout_left_o,
  output logic [NV*QAPP-1:0] xout_right_o
);
  localparam int unsigned DEG = 2 * DCH;
  localparam int unsigned NE  = NC * DEG;
  localparam app_t TERM_V = sat_app(TERM_LLR);

  app_t chan_a [NV];
  app_t xl_eff [NV], xr_eff [NV];
  app_t app_l_q [NV], app_r_q [NV];
  app_t xo_l_q [NV], xo_r_q [NV];
  ext_t c2v_q [NE];
  logic vld_q;

  app_t al [NV], ar [NV];
  app_t app_l_n [NV], app_r_n [NV];
  app_t xo_l_n [NV], xo_r_n [NV];
  app_t v2c [NC][DEG];
  ext_t c2v_n [NC][DEG];
  int   acc_l [NV], acc_r [NV];

  for (genvar j = 0; j < NV; j++) begin : g_io
    assign chan_a[j] = chan_i[j*QAPP +: QAPP];
    // neutral element on the first sub-block, termination on the last
    assign xl_eff[j] = first_i ? app_t'(0) : app_t'(xin_left_i[j*QAPP +: QAPP]);
    assign xr_eff[j] = last_i ? TERM_V : app_t'(xin_right_i[j*QAPP +: QAPP]);
    assign app_left_o[j*QAPP +: QAPP]   = app_l_q[j];
    assign app_right_o[j*QAPP +: QAPP]  = app_r_q[j];
    assign xout_left_o[j*QAPP +: QAPP]  = xo_l_q[j];
    assign xout_right_o[j*QAPP +: QAPP] = xo_r_q[j];
  end

  sc_row_xadd #(.N(NV), .SUB(1'b0)) u_in_l  (.a_i(app_l_q), .b_i(xl_eff), .y_o(al));
  sc_row_xadd #(.N(NV), .SUB(1'b0)) u_in_r  (.a_i(app_r_q), .b_i(xr_eff), .y_o(ar));
  sc_row_xadd #(.N(NV), .SUB(1'b1)) u_out_l (.a_i(app_l_n), .b_i(xl_eff), .y_o(xo_l_n));
  sc_row_xadd #(.N(NV), .SUB(1'b1)) u_out_r (.a_i(app_r_n), .b_i(xr_eff), .y_o(xo_r_n));

  for (genvar m = 0; m < NC; m++) begin : g_chk
    for (genvar k = 0; k < DCH; k++) begin : g_k
      localparam int VL = vn_idx(m, 0, k, NV, DCH, RSH);
      localparam int VR = vn_idx(m, 1, k, NV, DCH, RSH);
      assign v2c[m][k] =
          sat_app(int'(al[VL]) - int'(c2v_q[m*DEG + k]));
      assign v2c[m][DCH+k] =
          sat_app(int'(ar[VR]) - int'(c2v_q[m*DEG + DCH + k]));
    end
    sc_row_cnu #(.DEG(DEG)) u_cnu (.v2c_i(v2c[m]), .c2v_o(c2v_n[m]));
  end

  // APP rebuild: one saturation after summing all message deltas
  always_comb begin
    for (int j = 0; j < NV; j++) begin
      acc_l[j] = int'(al[j]);
      acc_r[j] = int'(ar[j]);
      for (int m = 0; m < NC; m++) begin
        for (int k = 0; k < DCH; k++) begin
          if (vn_idx(m, 0, k, NV, DCH, RSH) == j)
            acc_l[j] = acc_l[j] + int'(c2v_n[m][k]) - int'(c2v_q[m*DEG + k]);
          if (vn_idx(m, 1, k, NV, DCH, RSH) == j)
            acc_r[j] = acc_r[j] + int'(c2v_n[m][DCH+k]) - int'(c2v_q[m*DEG + DCH + k]);
        end
      end
      app_l_n[j] = sat_app(acc_l[j]);
      app_r_n[j] = sat_app(acc_r[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      for (int j = 0; j < NV; j++) begin
        app_l_q[j] <= '0;
        app_r_q[j] <= '0;
        xo_l_q[j]  <= '0;
        xo_r_q[j]  <= '0;
      end
      for (int e = 0; e < NE; e++) c2v_q[e] <= '0;
    end else if (load_i) begin
      vld_q <= 1'b0;
      for (int j = 0; j < NV; j++) begin
        app_l_q[j] <= '0;
        app_r_q[j] <= sat_app(int'(chan_a[j]));
        xo_l_q[j]  <= '0;
        xo_r_q[j]  <= '0;
      end
      for (int e = 0; e < NE; e++) c2v_q[e] <= '0;
    end else if (valid_i) begin
      vld_q <= 1'b1;
      for (int j = 0; j < NV; j++) begin
        app_l_q[j] <= app_l_n[j];
        app_r_q[j] <= app_r_n[j];
        xo_l_q[j]  <= xo_l_n[j];
        xo_r_q[j]  <= xo_r_n[j];
      end
      for (int m = 0; m < NC; m++)
        for (int d = 0; d < DEG; d++)
          c2v_q[m*DEG + d] <= c2v_n[m][d];
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
endmodule

// File: rtl/sc_row_proc_chk.sv
module sc_row_proc_chk
  import sc_row_pkg::*;
#(
  parameter int unsigned NV = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               valid_i,
  input logic               valid_o,
  input logic [NV*QAPP-1:0] app_left_o,
  input logic [NV*QAPP-1:0] app_right_o,
  input logic [NV*QAPP-1:0] xout_left_o,
  input logic [NV*QAPP-1:0] xout_right_o
);
  function automatic logic has_neg_max(input logic [NV*QAPP-1:0] v);
    logic r;
    r = 1'b0;
    for (int j = 0; j < NV; j++)
      if (v[j*QAPP +: QAPP] == {1'b1, {(QAPP-1){1'b0}}}) r = 1'b1;
    return r;
  endfunction

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !load_i) |=> valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !load_i) |=> !valid_o);
  // R11
  app_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !load_i) |=> ($stable(app_left_o) && $stable(app_right_o)
                               && $stable(xout_left_o) && $stable(xout_right_o)));
  // R2
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (app_left_o == '0 && xout_left_o == '0 && xout_right_o == '0));
  // R3
  app_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_neg_max(app_left_o) && !has_neg_max(app_right_o));
  // R9
  xout_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_neg_max(xout_left_o) && !has_neg_max(xout_right_o));
endmodule

bind sc_row_proc sc_row_proc_chk #(.NV(NV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .valid_i(valid_i),
  .valid_o(valid_o), .app_left_o(app_left_o), .app_right_o(app_right_o),
  .xout_left_o(xout_left_o), .xout_right_o(xout_right_o)
);

// File: tb/sc_row_proc_bench.sv
`timescale 1ns/1ps
module sc_row_proc_bench;
  localparam int NV = 8, NC = 4, DCH = 4, RSH = 2, TERM = 31;
  localparam int Q = 6, DEG = 2 * DCH, NE = NC * DEG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load, valid, first, last;
  logic [NV*Q-1:0] chan, xl, xr;
  logic valid_o;
  logic [NV*Q-1:0] app_l, app_r, xo_l, xo_r;

  int n_vec = 0, n_bad = 0;
  int ml [NV], mr [NV], mc [NE], exl [NV], exr [NV];

  always #2.5 clk = ~clk;

  sc_row_proc u_sc_row_proc (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .chan_i(chan), .valid_i(valid),
    .first_i(first), .last_i(last), .xin_left_i(xl), .xin_right_i(xr),
    .valid_o(valid_o), .app_left_o(app_l), .app_right_o(app_r),
    .xout_left_o(xo_l), .xout_right_o(xo_r)
  );

  function automatic int sa(input int x);
    return (x > 31) ? 31 : ((x < -31) ? -31 : x);
  endfunction
  function automatic int se(input int x);
    return (x > 7) ? 7 : ((x < -7) ? -7 : x);
  endfunction
  function automatic int el(input logic [NV*Q-1:0] v, input int j);
    logic signed [Q-1:0] s;
    s = v[j*Q +: Q];
    return int'(s);
  endfunction
  function automatic int vn(input int m, input int h, input int k);
    return (m * DCH + k + (h != 0 ? RSH : 0)) % NV;
  endfunction
  function automatic int rnd6();
    return int'($urandom_range(63)) - 32;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string ta, input string tx, input int vexp);
    chk("R10 valid_o", int'(valid_o), vexp);
    for (int j = 0; j < NV; j++) begin
      chk(ta, el(app_l, j), ml[j]);
      chk(ta, el(app_r, j), mr[j]);
      chk(tx, el(xo_l, j), exl[j]);
      chk(tx, el(xo_r, j), exr[j]);
    end
  endtask

  // reference iteration (R3..R9)
  task automatic model_iter(input logic f, input logic l);
    int al [NV], ar [NV], xle [NV], xre [NV], dl [NV], dr [NV], nc [NE];
    int v [DEG];
    for (int j = 0; j < NV; j++) begin
      xle[j] = f ? 0 : el(xl, j);
      xre[j] = l ? TERM : el(xr, j);
      al[j] = sa(ml[j] + xle[j]);
      ar[j] = sa(mr[j] + xre[j]);
      dl[j] = 0; dr[j] = 0;
    end
    for (int m = 0; m < NC; m++) begin
      for (int d = 0; d < DEG; d++) begin
        int a;
        a = (d < DCH) ? al[vn(m, 0, d)] : ar[vn(m, 1, d - DCH)];
        v[d] = sa(a - mc[m*DEG + d]);
      end
      for (int d = 0; d < DEG; d++) begin
        int mn, sg, s;
        mn = 31; sg = 0;
        for (int o = 0; o < DEG; o++) begin
          if (o != d) begin
            int mg;
            mg = (v[o] < 0) ? -v[o] : v[o];
            if (mg < mn) mn = mg;
            if (v[o] < 0) sg = sg ^ 1;
          end
        end
        s = mn - mn / 4;
        if (s > 7) s = 7;
        nc[m*DEG + d] = se(sg ? -s : s);
        if (d < DCH) dl[vn(m, 0, d)] += nc[m*DEG + d] - mc[m*DEG + d];
        else         dr[vn(m, 1, d - DCH)] += nc[m*DEG + d] - mc[m*DEG + d];
      end
    end
    for (int j = 0; j < NV; j++) begin
      ml[j] = sa(al[j] + dl[j]);
      mr[j] = sa(ar[j] + dr[j]);
      exl[j] = sa(ml[j] - xle[j]);
      exr[j] = sa(mr[j] - xre[j]);
    end
    for (int e = 0; e < NE; e++) mc[e] = nc[e];
  endtask

  task automatic do_load(input logic also_valid);
    @(negedge clk);
    for (int j = 0; j < NV; j++) chan[j*Q +: Q] = 6'(rnd6());
    if ($urandom_range(3) == 0) chan[5:0] = 6'b100000;
    load = 1'b1; valid = also_valid;
    @(negedge clk);
    load = 1'b0; valid = 1'b0;
    for (int j = 0; j < NV; j++) begin
      ml[j] = 0; mr[j] = sa(el(chan, j)); exl[j] = 0; exr[j] = 0;
    end
    for (int e = 0; e < NE; e++) mc[e] = 0;
    chk_all("R2 load app", "R2 load xout", 0);
  endtask

  task automatic do_iter(input logic f, input logic l, input string ta, input string tx);
    for (int j = 0; j < NV; j++) begin
      xl[j*Q +: Q] = 6'(rnd6());
      xr[j*Q +: Q] = 6'(rnd6());
    end
    if ($urandom_range(4) == 0) begin
      xl[Q-1:0] = 6'b100000; xr[Q-1:0] = 6'b011111;
    end
    first = f; last = l; valid = 1'b1;
    model_iter(f, l);
    @(negedge clk);
    valid = 1'b0;
    chk_all(ta, tx, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    load = 0; valid = 0; first = 0; last = 0; chan = '0; xl = '0; xr = '0;
    for (int j = 0; j < NV; j++) begin ml[j] = 0; mr[j] = 0; exl[j] = 0; exr[j] = 0; end
    for (int e = 0; e < NE; e++) mc[e] = 0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset app", "R1 reset xout", 0);

    // R2 load, with load taking priority over a concurrent valid
    do_load(1'b1);
    // R4 neutral left input on the first sub-block; R6 check update
    do_iter(1'b1, 1'b0, "R4 R6 app", "R9 xout");
    // R5 termination on the last sub-block; R7 scaling
    do_iter(1'b0, 1'b1, "R5 R7 app", "R9 xout");
    // R11 idle: new inputs, no valid, state held
    @(negedge clk);
    xl = '1; xr = '1;
    @(negedge clk);
    chk_all("R11 idle app", "R11 idle xout", 0);
    // R3 saturation with extreme exchange inputs
    do_load(1'b0);
    for (int j = 0; j < NV; j++) begin xl[j*Q +: Q] = 6'b011111; xr[j*Q +: Q] = 6'b011111; end
    first = 0; last = 0; valid = 1'b1;
    model_iter(1'b0, 1'b0);
    @(negedge clk);
    valid = 1'b0;
    chk_all("R3 sat app", "R9 xout", 1);

    for (int b = 0; b < 60; b++) begin
      do_load(1'($urandom_range(1)));
      for (int it = 0; it < 1 + int'($urandom_range(5)); it++) begin
        do_iter(1'($urandom_range(1)), 1'($urandom_range(1)), "R8 app", "R9 xout");
        if ($urandom_range(3) == 0) begin
          @(negedge clk);
          chk_all("R11 idle app", "R11 idle xout", 0);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule